// File: doc/BRIEF.md
# Watermark Byte Queue with Per-Side Step Enables

This block is an eight-entry, byte-wide first-in first-out queue meant to sit on either side of a serial peripheral, as its outgoing or its incoming queue. Producer and consumer share one clock. Each side has its own step-enable qualifier, so one side can advance at the serial bit rate while the other advances at bus rate. A side moves only on a cycle where both its increment strobe and its enable are high.

The queue gives full and empty flags. Its read port always shows the oldest stored byte. It also compares the number of stored bytes with a 3-bit threshold and drives two level flags. The outgoing flag is high while the queue holds fewer bytes than the threshold, meaning it needs refilling. The incoming flag is high while the queue holds more bytes than the threshold, meaning it should be drained. The owner decides which flag it uses.

Top module: `wm_byte_fifo`

## Requirements
- R1: While reset (`rst_n` low) is applied, and directly after it, the queue is empty: `empty`=1, `full`=0, `rx_mark`=0, and `tx_mark` equals (`level_mark` > 0).
- R2: A byte is stored only on a rising edge where `wr_inc` and `wr_en` are both 1. The oldest byte is removed only on an edge where `rd_inc` and `rd_en` are both 1. If either signal of a pair is low, that side does nothing.
- R3: Bytes leave in the order they were written, and `rd_data` always shows the oldest stored byte whenever `empty`=0.
- R4: `tx_mark` is 1 exactly when the stored count is strictly less than `level_mark`.
- R5: `rx_mark` is 1 exactly when the stored count is strictly greater than `level_mark`.
- R6: `full` is 1 exactly when 8 bytes are stored. A write attempted while full is dropped and leaves the stored bytes and their order unchanged.
- R7: A read attempted while empty is ignored. The next byte written then appears on `rd_data`.
- R8: An accepted write and an accepted read on the same edge leave the count, `full` and `empty` unchanged. When the queue is full and both strobes are enabled, the read is taken and the write is dropped, leaving 7 bytes.
- R9: With `level_mark`=0, `tx_mark` is never 1 and `rx_mark` equals not `empty`.
- R10: Pointers wrap after eight entries, and ordering and flags stay correct across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Producer-side step enable |
| rd_en | input | 1 | Consumer-side step enable |
| wr_inc | input | 1 | Write strobe |
| rd_inc | input | 1 | Read (pop) strobe |
| wr_data | input | 8 | Byte to store |
| level_mark | input | 3 | Threshold for the level flags |
| rd_data | output | 8 | Oldest stored byte |
| full | output | 1 | Eight bytes stored |
| empty | output | 1 | No bytes stored |
| tx_mark | output | 1 | Count below threshold |
| rx_mark | output | 1 | Count above threshold |

## Verification
The pointers are the only state. An accepted write or read therefore shows on `full`, `empty`, `rd_data` and both level flags one edge later. A change on `level_mark` alone reaches the level flags in the same cycle, because that path is combinational. The bench drives stimulus just after a falling edge and lets one rising edge pass. It then samples every output at the following falling edge and compares it with a queue model that applies the acceptance rules to the pre-edge count. For threshold sweeps, the bench changes only `level_mark` and samples a short delay later, with no clock edge in between.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

  localparam int unsigned WMF_DATA_W = 8;
  localparam int unsigned WMF_ADDR_W = 3;

  typedef struct packed {
    logic full;
    logic empty;
    logic tx_mark;
    logic rx_mark;
  } wmf_flags_t;

endpackage

// File: rtl/wmf_ptr.sv
module wmf_ptr #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step) ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr)); // R2

endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = we && (waddr == ADDR_W'(e));
    always_ff @(posedge clk) begin
      if (slot_we) slot[e] <= wdata;
    end
  end

  assign rdata = slot[raddr];

endmodule

// File: rtl/wmf_status.sv
module wmf_status
  import wmf_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   wptr,
  input  logic [ADDR_W:0]   rptr,
  input  logic [ADDR_W-1:0] mark,
  output wmf_flags_t        flags
);

  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] count;
  logic [PTR_W-1:0] mark_ext;

  assign count    = wptr - rptr;
  assign mark_ext = {1'b0, mark};

  always_comb begin
    flags.empty   = (wptr == rptr);
    flags.full    = (wptr[ADDR_W] != rptr[ADDR_W]) &&
                    (wptr[ADDR_W-1:0] == rptr[ADDR_W-1:0]);
    flags.tx_mark = (count < mark_ext);
    flags.rx_mark = (count > mark_ext);
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PTR_W'(DEPTH)); // R6
  AST_EMPTY_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    flags.empty |-> !flags.rx_mark); // R5
  AST_ZERO_MARK_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mark == '0) |-> !flags.tx_mark); // R9

endmodule

// File: rtl/wm_byte_fifo.sv
module wm_byte_fifo
  import wmf_pkg::*;
#(
  parameter int unsigned DATA_W = WMF_DATA_W,
  parameter int unsigned ADDR_W = WMF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              wr_inc,
  input  logic              rd_inc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] level_mark,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              tx_mark,
  output logic              rx_mark
);

  localparam int unsigned PTR_W = ADDR_W + 1;

  wmf_flags_t       flags;
  logic             wr_acc;
  logic             rd_acc;
  logic [1:0]       step_vec;
  logic [PTR_W-1:0] ptr_vec [2];

  // a side advances only when strobe and enable agree and the state allows it
  assign wr_acc   = wr_inc && wr_en && !flags.full;
  assign rd_acc   = rd_inc && rd_en && !flags.empty;
  assign step_vec = {rd_acc, wr_acc};

  for (genvar s = 0; s < 2; s++) begin : g_side
    wmf_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (step_vec[s]),
      .ptr  (ptr_vec[s])
    );
  end

  wmf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .we   (wr_acc),
    .waddr(ptr_vec[0][ADDR_W-1:0]),
    .wdata(wr_data),
    .raddr(ptr_vec[1][ADDR_W-1:0]),
    .rdata(rd_data)
  );

  wmf_status #(.ADDR_W(ADDR_W)) u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .wptr (ptr_vec[0]),
    .rptr (ptr_vec[1]),
    .mark (level_mark),
    .flags(flags)
  );

  assign full    = flags.full;
  assign empty   = flags.empty;
  assign tx_mark = flags.tx_mark;
  assign rx_mark = flags.rx_mark;

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R6
  AST_MARKS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_mark && rx_mark)); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(rd_inc && rd_en)) |=> (full && $stable(rd_data))); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(wr_inc && wr_en)) |=> empty); // R7
  AST_SIMUL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inc && wr_en && rd_inc && rd_en && !full && !empty)
      |=> ($stable(full) && $stable(empty))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_inc && wr_en) && !(rd_inc && rd_en))
      |=> ($stable(empty) && $stable(full) && $stable(rd_data))); // R2

endmodule

// File: tb/test_wm_byte_fifo.sv
module test_wm_byte_fifo;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, wr_inc, rd_inc;
  logic [7:0] wr_data;
  logic [2:0] level_mark;
  logic [7:0] rd_data;
  logic       full, empty, tx_mark, rx_mark;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] mq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_byte_fifo i_wm_byte_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_inc(wr_inc), .rd_inc(rd_inc), .wr_data(wr_data),
    .level_mark(level_mark), .rd_data(rd_data), .full(full),
    .empty(empty), .tx_mark(tx_mark), .rx_mark(rx_mark)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    int cnt = mq.size();
    chk({tag, " empty"}, int'(empty), int'(cnt == 0));
    chk({tag, " full"}, int'(full), int'(cnt == 8));
    chk({tag, " tx_mark R4"}, int'(tx_mark), int'(cnt < int'(level_mark)));
    chk({tag, " rx_mark R5"}, int'(rx_mark), int'(cnt > int'(level_mark)));
    if (cnt > 0) chk({tag, " rd_data R3"}, int'(rd_data), int'(mq[0]));
  endtask

  // one clock: drive after falling edge, sample at next falling edge
  task automatic cyc(input logic wi, input logic we, input logic [7:0] wd,
                     input logic ri, input logic re);
    bit wacc, racc;
    wr_inc = wi; wr_en = we; wr_data = wd; rd_inc = ri; rd_en = re;
    wacc = wi && we && (mq.size() < 8);
    racc = ri && re && (mq.size() > 0);
    @(posedge clk);
    @(negedge clk);
    if (racc) void'(mq.pop_front());
    if (wacc) mq.push_back(wd);
    wr_inc = 1'b0; rd_inc = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_reset();
    level_mark = 3'd3;
    #1;
    chk("R1 empty in reset", int'(empty), 1);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 tx_mark in reset", int'(tx_mark), 1);
    chk("R1 rx_mark in reset", int'(rx_mark), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after release");
  endtask

  task automatic t_enables();
    level_mark = 3'd2;
    cyc(1'b1, 1'b0, 8'hA1, 1'b0, 1'b0);
    chk("R2 write without enable", int'(empty), 1);
    cyc(1'b0, 1'b1, 8'hA2, 1'b0, 1'b0);
    chk("R2 enable without strobe", int'(empty), 1);
    cyc(1'b1, 1'b1, 8'hA3, 1'b0, 1'b0);
    chk_state("R2 enabled write");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R2 read without enable", int'(rd_data), 8'hA3);
    chk_state("R2 read blocked");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_state("R2 enabled read");
  endtask

  task automatic t_empty_read();
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_state("R7 read on empty");
    cyc(1'b1, 1'b1, 8'h5C, 1'b0, 1'b0);
    chk("R7 next byte shown", int'(rd_data), 8'h5C);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_state("R7 drained");
  endtask

  task automatic t_fill_order();
    level_mark = 3'd5;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b1, 8'(8'h30 + i * 7), 1'b0, 1'b0);
      chk_state("R3 fill");
    end
    chk("R6 full at eight", int'(full), 1);
    cyc(1'b1, 1'b1, 8'hEE, 1'b0, 1'b0);
    chk_state("R6 write while full dropped");
    for (int i = 0; i < 8; i++) begin
      chk("R6 order kept", int'(rd_data), int'(8'(8'h30 + i * 7)));
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
      chk_state("R3 drain");
    end
  endtask

  task automatic t_marks();
    for (int c = 0; c <= 8; c++) begin
      for (int m = 0; m < 8; m++) begin
        level_mark = 3'(m);
        #1;
        chk("R4 tx sweep", int'(tx_mark), int'(c < m));
        chk("R5 rx sweep", int'(rx_mark), int'(c > m));
      end
      if (c < 8) cyc(1'b1, 1'b1, 8'(c), 1'b0, 1'b0);
    end
    while (mq.size() > 0) cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_wm0();
    level_mark = 3'd0;
    #1;
    chk("R9 tx at zero mark empty", int'(tx_mark), 0);
    chk("R9 rx at zero mark empty", int'(rx_mark), 0);
    cyc(1'b1, 1'b1, 8'h11, 1'b0, 1'b0);
    chk("R9 rx nonempty", int'(rx_mark), 1);
    chk("R9 tx nonempty", int'(tx_mark), 0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R9 rx back to empty", int'(rx_mark), 0);
  endtask

  task automatic t_simul();
    level_mark = 3'd3;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 8'(8'h70 + i), 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b1, 8'(8'h90 + i), 1'b1, 1'b1);
      chk("R8 count kept", int'(rx_mark || tx_mark), 0);
      chk_state("R8 simultaneous");
    end
    while (mq.size() < 8) cyc(1'b1, 1'b1, 8'(8'hB0 + mq.size()), 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 8'hFF, 1'b1, 1'b1);
    chk("R8 full read wins", int'(full), 0);
    chk_state("R8 at full");
    while (mq.size() > 0) begin
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
      chk_state("R8 drain");
    end
  endtask

  task automatic t_wrap();
    logic [7:0] v = 8'h1D;
    level_mark = 3'd4;
    for (int i = 0; i < 60; i++) begin
      v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
      cyc(v[0] | v[1], 1'b1, v, v[2] & (i > 3), v[3] | v[4]);
      chk_state("R10 wrap");
    end
    while (mq.size() > 0) cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_state("R10 final drain");
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_inc = 1'b0; rd_inc = 1'b0;
    wr_data = 8'h00; level_mark = 3'd0;
    repeat (3) @(negedge clk);
    t_reset();
    t_enables();
    t_empty_read();
    t_fill_order();
    t_marks();
    t_wm0();
    t_simul();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule